// File: doc/BRIEF.md
# Synchronous Serial Port with Busy Handshake

This block moves one word at a time over a three-wire serial link: a serial clock, a data line into the port and a data line out of it. A host writes a transmit word, picks an 8-bit or 16-bit word length and later reads the received word. The port either generates the serial clock itself (master mode) or follows a clock driven by the remote side (slave mode). Both directions shift at the same time, most significant bit first.

A busy line tells the remote side when the port cannot take another word. It rises when the last bit of a word has been captured. It stays high until the host reads the received word or loads a new transmit word. In slave mode, clock edges that arrive while busy is high are discarded. A done flag, kept separate from busy, reports a finished word to the host until the host reads it.

In master mode the clock half period is programmable. Logic holds it to a floor of three system clocks, so a full period is never shorter than six system clocks and the edge detector on the far side always has a settled level to look at.

Top module: `siob_port`

## Requirements
- R1: After reset, `busy` and `xfer_done` are 0, `sck_out` is 1 and `rx_word` is 0.
- R2: With `word16`=0 a word is 8 bits and `rx_word[15:8]` reads 0; with `word16`=1 a word is 16 bits. A master transfer produces exactly that many rising edges on `sck_out`.
- R3: Data moves most significant bit first: bit 15 in 16-bit mode, bit 7 in 8-bit mode. The receiver samples `sdi` on rising serial clock edges. `sdo` shows the top bit from the load and advances one bit on every falling edge except the first of the word.
- R4: In master mode, each high and low phase of `sck_out` lasts max(`half_div`, 3) system clocks. A `half_div` below 3 acts as 3.
- R5: The serial clock idles high. In master mode a `tx_load` while no transfer is running starts a transfer. In slave mode `sck_out` stays 1.
- R6: `xfer_done` and `busy` rise together when the final bit is captured. In master mode this happens in the same cycle that `sck_out` rises for the last time. In slave mode it happens on the third system clock edge after `sck_in` goes high.
- R7: `busy` is cleared by a `rx_read` or a `tx_load` pulse. `xfer_done` is cleared only by `rx_read`.
- R8: In slave mode, serial clock edges that arrive while `busy` is 1 have no effect: `rx_word`, `sdo`, `xfer_done` and `busy` keep their values.
- R9: In master mode `sdo` changes in the same cycle that `sck_out` falls. In slave mode it changes on the third system clock edge after `sck_in` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_master | input | 1 | 1: port drives the serial clock; 0: port follows `sck_in` |
| word16 | input | 1 | 1: 16-bit words; 0: 8-bit words |
| half_div | input | 6 | Master clock half period in system clocks (floor of 3) |
| tx_load | input | 1 | One-cycle pulse that loads `tx_word` |
| tx_word | input | 16 | Word to transmit (low byte in 8-bit mode) |
| rx_read | input | 1 | One-cycle pulse that acknowledges the received word |
| rx_word | output | 16 | Last completed received word |
| xfer_done | output | 1 | A word has finished and has not been read yet |
| sck_in | input | 1 | Serial clock from the remote side (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Port cannot accept a further word |

## Verification
In master mode, `sck_out`, `sdo`, `busy` and `xfer_done` all come from registers that update on the same system clock edge. The bench samples every system clock on the falling edge and checks `sdo` and completion in the very sample where a change of `sck_out` first appears. In slave mode, an `sck_in` transition passes through two synchronizer stages and one edge compare, so its effect is due on the third rising system clock edge. The bench therefore reads `busy` and `sdo` after the second edge, expecting the old value, and again after the third, expecting the new one. Host pulses act on the next edge and are checked in the sample right after.

// File: rtl/siob_pkg.sv
package siob_pkg;

    // Serial clock events seen by the shift engine in one system cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } siob_edge_t;

endpackage

// File: rtl/siob_sync.sv
module siob_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/siob_clkgen.sv
module siob_clkgen
    import siob_pkg::*;
#(
    parameter int DIV_W    = 6,
    parameter int CNT_W    = 5,
    parameter int HALF_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic [CNT_W-1:0] nbits,
    output logic             sck,
    output logic             active,
    output siob_edge_t       edge_o
);

    localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(HALF_MIN);

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [DIV_W-1:0] cnt;
        logic [CNT_W-1:0] rises;
    } gen_st_t;

    gen_st_t    st_d, st_q;
    logic [DIV_W-1:0] half;

    always_comb begin
        half   = (half_div < HALF_FLOOR) ? HALF_FLOOR : half_div;
        st_d   = st_q;
        edge_o = '0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.sck    = 1'b1;
                st_d.cnt    = '0;
                st_d.rises  = '0;
            end
        end else if (st_q.cnt == half - DIV_W'(1)) begin
            st_d.cnt = '0;
            st_d.sck = !st_q.sck;
            if (st_q.sck) begin
                edge_o.fall = 1'b1;
            end else begin
                edge_o.rise = 1'b1;
                st_d.rises  = st_q.rises + CNT_W'(1);
                if (st_q.rises == nbits - CNT_W'(1)) st_d.active = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, sck: 1'b1, cnt: '0, rises: '0};
        else        st_q <= st_d;
    end

    assign sck    = st_q.sck;
    assign active = st_q.active;

endmodule

// File: rtl/siob_shift.sv
module siob_shift
    import siob_pkg::*;
#(
    parameter int WMAX  = 16,
    parameter int WMIN  = 8,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WMAX-1:0]  load_word,
    input  logic             wide,
    input  logic [CNT_W-1:0] nbits,
    input  siob_edge_t       edge_i,
    input  logic             sdi,
    output logic             sdo,
    output logic             last,
    output logic [WMAX-1:0]  rx_next
);

    localparam int PAD = WMAX - WMIN;

    typedef struct packed {
        logic [WMAX-1:0]  tx_sh;
        logic [WMAX-1:0]  rx_sh;
        logic [CNT_W-1:0] bits;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [WMAX-1:0] rx_shift;

    always_comb begin
        st_d     = st_q;
        last     = 1'b0;
        rx_shift = {st_q.rx_sh[WMAX-2:0], sdi};
        rx_next  = wide ? rx_shift : WMAX'(rx_shift[WMIN-1:0]);
        if (load) begin
            st_d.tx_sh = wide ? load_word : (WMAX'(load_word[WMIN-1:0]) << PAD);
            st_d.rx_sh = '0;
            st_d.bits  = '0;
        end else if (edge_i.rise) begin
            st_d.rx_sh = rx_shift;
            if (st_q.bits == nbits - CNT_W'(1)) begin
                last      = 1'b1;
                st_d.bits = '0;
            end else begin
                st_d.bits = st_q.bits + CNT_W'(1);
            end
        end else if (edge_i.fall && (st_q.bits != '0)) begin
            st_d.tx_sh = st_q.tx_sh << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo = st_q.tx_sh[WMAX-1];

endmodule

// File: rtl/siob_port.sv
module siob_port
    import siob_pkg::*;
#(
    parameter int WMAX     = 16,
    parameter int WMIN     = 8,
    parameter int DIV_W    = 6,
    parameter int HALF_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_master,
    input  logic             word16,
    input  logic [DIV_W-1:0] half_div,
    input  logic             tx_load,
    input  logic [WMAX-1:0]  tx_word,
    input  logic             rx_read,
    output logic [WMAX-1:0]  rx_word,
    output logic             xfer_done,
    input  logic             sck_in,
    output logic             sck_out,
    input  logic             sdi,
    output logic             sdo,
    output logic             busy
);

    localparam int CNT_W = $clog2(WMAX + 1);

    typedef struct packed {
        logic [WMAX-1:0] rx;
        logic            done;
        logic            busy;
        logic            sck_prev;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [1:0]       pins_s;
    logic             sck_s, sdi_s;
    logic [CNT_W-1:0] nbits;
    logic             gen_sck, gen_active, gen_start, sh_load;
    siob_edge_t       gen_edge, slv_edge, edge_sel;
    logic             word_last;
    logic [WMAX-1:0]  rx_next;
    logic             sel_rise, sel_fall;

    // bit 0: serial clock (idles high), bit 1: serial data
    siob_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi, sck_in}),
        .sync_o  (pins_s)
    );

    assign sck_s = pins_s[0];
    assign sdi_s = pins_s[1];
    assign nbits = word16 ? CNT_W'(WMAX) : CNT_W'(WMIN);

    assign gen_start = mode_master && tx_load && !gen_active;
    assign sh_load   = tx_load && !(mode_master && gen_active);

    siob_clkgen #(.DIV_W(DIV_W), .CNT_W(CNT_W), .HALF_MIN(HALF_MIN)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gen_start),
        .half_div (half_div),
        .nbits    (nbits),
        .sck      (gen_sck),
        .active   (gen_active),
        .edge_o   (gen_edge)
    );

    always_comb begin
        slv_edge.rise = sck_s && !st_q.sck_prev;
        slv_edge.fall = !sck_s && st_q.sck_prev;
        if (mode_master)   edge_sel = gen_edge;
        else if (st_q.busy) edge_sel = '0;
        else               edge_sel = slv_edge;
        sel_rise = edge_sel.rise;
        sel_fall = edge_sel.fall;
    end

    siob_shift #(.WMAX(WMAX), .WMIN(WMIN), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (tx_word),
        .wide      (word16),
        .nbits     (nbits),
        .edge_i    (edge_sel),
        .sdi       (sdi_s),
        .sdo       (sdo),
        .last      (word_last),
        .rx_next   (rx_next)
    );

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        if (word_last) begin
            st_d.rx   = rx_next;
            st_d.done = 1'b1;
            st_d.busy = 1'b1;
        end else begin
            if (rx_read) begin
                st_d.done = 1'b0;
                st_d.busy = 1'b0;
            end
            if (tx_load) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rx: '0, done: 1'b0, busy: 1'b0, sck_prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rx_word   = st_q.rx;
    assign xfer_done = st_q.done;
    assign busy      = st_q.busy;
    assign sck_out   = mode_master ? gen_sck : 1'b1;

endmodule

// File: rtl/siob_port_chk.sv
module siob_port_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_master,
    input logic tx_load,
    input logic rx_read,
    input logic xfer_done,
    input logic busy,
    input logic sck_out,
    input logic sdo,
    input logic sel_fall
);

    // R6: completion raises both flags together
    a_r6_done_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> busy);

    // R6: in master mode completion coincides with the last rising clock
    a_r6_master_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && $rose(xfer_done)) |-> $rose(sck_out));

    // R7: busy drops only after a host read or load
    a_r7_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rx_read || tx_load));

    // R7: done drops only after a host read
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_done) |-> $past(rx_read));

    // R4: generated clock phases last at least three system clocks
    a_r4_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !$stable(sck_out)) |->
            ($past(sck_out) == $past(sck_out, 2)) && ($past(sck_out, 2) == $past(sck_out, 3)));

    // R9, R8: data out moves only on an accepted falling edge or a load
    a_r9_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sel_fall || tx_load));

endmodule

bind siob_port siob_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .tx_load     (tx_load),
    .rx_read     (rx_read),
    .xfer_done   (xfer_done),
    .busy        (busy),
    .sck_out     (sck_out),
    .sdo         (sdo),
    .sel_fall    (sel_fall)
);

// File: tb/tb_siob_port.sv
module tb_siob_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_master = 1'b1;
    logic        word16 = 1'b1;
    logic [5:0]  half_div = 6'd3;
    logic        tx_load = 1'b0;
    logic [15:0] tx_word = '0;
    logic        rx_read = 1'b0;
    logic [15:0] rx_word;
    logic        xfer_done;
    logic        sck_in = 1'b1;
    logic        sck_out;
    logic        sdi_drv = 1'b0;
    logic        sdi_w;
    logic        sdo;
    logic        busy;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    assign sdi_w = mode_master ? sdo : sdi_drv;

    siob_port dut (
        .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .word16(word16),
        .half_div(half_div), .tx_load(tx_load), .tx_word(tx_word), .rx_read(rx_read),
        .rx_word(rx_word), .xfer_done(xfer_done), .sck_in(sck_in), .sck_out(sck_out),
        .sdi(sdi_w), .sdo(sdo), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [15:0] w);
        @(negedge clk);
        tx_word = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic run_master(input bit w16, input int h, input logic [15:0] pat);
        int n = w16 ? 16 : 8;
        int hh = (h < 3) ? 3 : h;
        logic [15:0] exp = w16 ? pat : {8'h00, pat[7:0]};
        int rises = 0, falls = 0, run = 0, nchg = 0, bad_run = 0, bad_sdo = 0, guard = 0;
        bit last_was_rise = 0;
        logic prev;
        @(negedge clk);
        mode_master = 1'b1;
        word16 = w16;
        half_div = 6'(h);
        check(sck_out == 1'b1, "R5 idle clock high", sck_out, 1);
        pulse_load(pat);
        prev = sck_out;
        while (!xfer_done && guard < 2000) begin
            last_was_rise = 0;
            if (sck_out != prev) begin
                if (nchg > 0 && run != hh) bad_run++;
                run = 1;
                nchg++;
                if (!sck_out) begin
                    int idx;
                    falls++;
                    idx = n - ((falls == 1) ? 1 : falls);
                    if (idx >= 0 && sdo != pat[idx]) bad_sdo++;
                end else begin
                    rises++;
                    last_was_rise = 1;
                end
            end else begin
                run++;
            end
            prev = sck_out;
            if (!xfer_done) begin
                @(negedge clk);
                guard++;
            end
        end
        if (sck_out != prev && sck_out) begin
            rises++;
            last_was_rise = 1;
            if (run != hh) bad_run++;
        end
        check(rises == n, "R2 rising edge count", rises, n);
        check(bad_run == 0, "R4 phase length", bad_run, 0);
        check(bad_sdo == 0, "R3/R9 sdo at falling edges", bad_sdo, 0);
        check(last_was_rise, "R6 done with last rise", last_was_rise, 1);
        check(rx_word == exp, "R2/R3 loopback word", rx_word, exp);
        check(busy == 1'b1, "R6 busy at completion", busy, 1);
        pulse_read();
        check(!busy && !xfer_done, "R7 read clears flags", {busy, xfer_done}, 0);
    endtask

    task automatic slave_word(input bit w16, input logic [15:0] txp,
                              input logic [15:0] rxp, output logic [15:0] cap);
        int n = w16 ? 16 : 8;
        cap = '0;
        for (int i = 0; i < n; i++) begin
            int b = n - 1 - i;
            @(negedge clk);
            sck_in = 1'b0;
            sdi_drv = rxp[b];
            if (i == 1) begin
                @(negedge clk);
                @(negedge clk);
                check(sdo == txp[n-1], "R9 sdo holds 2 cycles", sdo, txp[n-1]);
                @(negedge clk);
                check(sdo == txp[n-2], "R9 sdo moves on 3rd", sdo, txp[n-2]);
            end else begin
                repeat (3) @(negedge clk);
            end
            cap[b] = sdo;
            sck_in = 1'b1;
            if (i == n - 1) begin
                @(negedge clk);
                @(negedge clk);
                check(busy == 1'b0, "R6 slave busy not before 3rd edge", busy, 0);
                @(negedge clk);
                check(busy && xfer_done, "R6 slave busy and done on 3rd edge",
                      {busy, xfer_done}, 3);
            end else begin
                repeat (3) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] cap;
        logic [15:0] held;
        logic        sdo_held;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(xfer_done == 1'b0, "R1 done after reset", xfer_done, 0);
        check(sck_out == 1'b1, "R1 clock after reset", sck_out, 1);
        check(rx_word == 16'h0, "R1 rx after reset", rx_word, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int w = 0; w < 2; w++) begin
            for (int hi = 0; hi < 3; hi++) begin
                for (int p = 0; p < 6; p++) begin
                    int hv = (hi == 0) ? 1 : ((hi == 1) ? 3 : 5);
                    logic [15:0] pat = 16'hC35A ^ (16'h1357 * 16'(p + 1)) ^ 16'(hv << p);
                    run_master(w[0], hv, pat);
                end
            end
        end

        // slave mode, 16-bit word
        @(negedge clk);
        mode_master = 1'b0;
        word16 = 1'b1;
        pulse_load(16'hA5C3);
        check(sck_out == 1'b1, "R5 slave clock stays high", sck_out, 1);
        slave_word(1'b1, 16'hA5C3, 16'h3C96, cap);
        check(rx_word == 16'h3C96, "R3 slave rx word", rx_word, 16'h3C96);
        check(cap == 16'hA5C3, "R3 slave tx bits msb first", cap, 16'hA5C3);
        check(sck_out == 1'b1, "R5 slave clock idle", sck_out, 1);

        // clocks while busy are dropped
        held = rx_word;
        sdo_held = sdo;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            sck_in = 1'b0;
            sdi_drv = ~sdi_drv;
            repeat (4) @(negedge clk);
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        check(rx_word == held, "R8 rx unchanged while busy", rx_word, held);
        check(sdo == sdo_held, "R8 sdo unchanged while busy", sdo, sdo_held);
        check(busy && xfer_done, "R8 flags kept while busy", {busy, xfer_done}, 3);

        // load clears busy only
        @(negedge clk);
        word16 = 1'b0;
        pulse_load(16'h00B4);
        check(busy == 1'b0, "R7 load clears busy", busy, 0);
        check(xfer_done == 1'b1, "R7 load keeps done", xfer_done, 1);
        check(rx_word == held, "R7 load keeps rx", rx_word, held);
        pulse_read();
        check(xfer_done == 1'b0, "R7 read clears done", xfer_done, 0);

        // slave mode, 8-bit word
        slave_word(1'b0, 16'h00B4, 16'h005E, cap);
        check(rx_word == 16'h005E, "R2 slave 8-bit rx upper zero", rx_word, 16'h005E);
        check(cap[7:0] == 8'hB4, "R2 slave 8-bit tx bits", cap[7:0], 8'hB4);
        pulse_read();
        check(!busy && !xfer_done, "R7 read clears both", {busy, xfer_done}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule